// File: doc/BRIEF.md
# Isolated I/O Port Decoder

This block is the I/O-space side of a 16-bit processor bus that keeps I/O apart from memory. It watches a 16-bit I/O address, a memory/I-O space select line and separate read and write strobes. It serves two fixed ports. One is an 8-bit input port that returns the state of eight switches. The other is an 8-bit output latch that holds a byte for eight LEDs.

Both ports are decoded against the full 16-bit address. A port number given as an 8-bit immediate reaches the bus with the upper byte zero. A port number taken from a register is passed through unchanged. Both forms therefore reach the same ports.

The two port addresses differ only in address bit 1. All other bits go through one shared comparison. Cycles in memory space never reach either port. The read path is combinational: it stands in for a tri-state buffer. It has a data output that is forced to zero when the buffer is idle, plus a separate output-enable that shows when the buffer would drive the bus.

Top module: `iso_io_port`

## Requirements
- R1: While rst_ni is low and after it rises, led_o is 00h. With no strobe active, rdata_o is 00h and rd_oe_o is 0.
- R2: In the same cycle as a read of the input port, rd_oe_o is 1 and rdata_o equals sw_i. A read of the input port is io_mem_i=0, rd_i=1 and addr_i=00F0h.
- R3: Switch k maps to data bit k. A switch that is on (sw_i[k]=1) reads as 1 and a switch that is off reads as 0.
- R4: A write to the output port captures wdata_i at that rising clock edge. A write to the output port is io_mem_i=0, wr_i=1 and addr_i=00F2h. led_o shows the captured value after the edge and holds it until the next such write.
- R5: Any cycle with io_mem_i=1 (memory space) leaves led_o unchanged and keeps rd_oe_o at 0 and rdata_o at 00h, whatever the address.
- R6: All 16 address bits are decoded. An address with any of bits 15..8 set reaches neither port, so 01F0h, 80F2h and FFF0h do not alias.
- R7: A read of any address other than 00F0h gives rdata_o=00h and rd_oe_o=0; this includes 00F2h, because the output port cannot be read back. A write to any address other than 00F2h leaves led_o unchanged; this includes 00F0h.
- R8: When rd_i and wr_i are both high in one cycle, each is decoded on its own. At 00F2h the latch loads and the read stays idle. At 00F0h the switches are driven and the latch holds.
- R9: A read of the switches followed by a write of that byte to 00F2h makes led_o equal the switch state one clock edge after the write strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| io_mem_i | input | 1 | Address space select: 0 = I/O, 1 = memory |
| rd_i | input | 1 | Read strobe, active high |
| wr_i | input | 1 | Write strobe, active high |
| addr_i | input | 16 | I/O address A15..A0 |
| wdata_i | input | 8 | Write data from the bus |
| sw_i | input | 8 | Switch states, 1 = on |
| rdata_o | output | 8 | Read data, 00h when the buffer is idle |
| rd_oe_o | output | 1 | High while the input buffer would drive the bus |
| led_o | output | 8 | Output latch contents driving the LEDs |

## Verification
The two functions that can meet in one cycle are the combinational read of the switch buffer and the clocked load of the LED latch. Both are triggered when rd_i and wr_i are held high together at each of the two port addresses.

The read result is judged in the same cycle. The latch is judged just after the next rising edge. The rule is that only the port matching the address responds: at 00F2h the latch loads while rdata_o stays 00h, and at 00F0h the switches appear while led_o keeps its old byte.

Full sweeps of the address space in both space-select states show that no other address, and no memory cycle, reaches either port.

// File: rtl/iso_io_pkg.sv
package iso_io_pkg;
  localparam int unsigned IO_ADDR_W  = 16;
  localparam int unsigned IO_DATA_W  = 8;
  localparam logic [IO_ADDR_W-1:0] IN_PORT_ADDR  = 16'h00F0;
  localparam logic [IO_ADDR_W-1:0] OUT_PORT_ADDR = 16'h00F2;

  typedef struct packed {
    logic in_rd;   // input buffer enabled
    logic out_wr;  // output latch load
  } io_sel_t;
endpackage

// File: rtl/io_addr_decode.sv
module io_addr_decode
  import iso_io_pkg::*;
#(
  parameter int unsigned ADDR_W = IO_ADDR_W,
  parameter logic [ADDR_W-1:0] IN_ADDR  = IN_PORT_ADDR[ADDR_W-1:0],
  parameter logic [ADDR_W-1:0] OUT_ADDR = OUT_PORT_ADDR[ADDR_W-1:0]
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              io_mem_i,
  input  logic              rd_i,
  input  logic              wr_i,
  output io_sel_t           sel_o
);
  // bits where the two port addresses differ are excluded from the shared compare
  localparam logic [ADDR_W-1:0] DIFF_MASK = IN_ADDR ^ OUT_ADDR;

  logic [ADDR_W-1:0] shared_ok;
  logic [ADDR_W-1:0] in_ok;
  logic [ADDR_W-1:0] out_ok;

  for (genvar b = 0; b < ADDR_W; b++) begin : g_bit
    if (DIFF_MASK[b]) begin : g_diff
      assign shared_ok[b] = 1'b1;
      assign in_ok[b]     = (addr_i[b] == IN_ADDR[b]);
      assign out_ok[b]    = (addr_i[b] == OUT_ADDR[b]);
    end else begin : g_same
      assign shared_ok[b] = (addr_i[b] == IN_ADDR[b]);
      assign in_ok[b]     = 1'b1;
      assign out_ok[b]    = 1'b1;
    end
  end

  logic io_cycle;
  logic shared_hit;
  assign io_cycle   = ~io_mem_i;
  assign shared_hit = &shared_ok;

  always_comb begin
    sel_o.in_rd  = io_cycle & rd_i & shared_hit & (&in_ok);
    sel_o.out_wr = io_cycle & wr_i & shared_hit & (&out_ok);
  end
endmodule

// File: rtl/io_in_buffer.sv
module io_in_buffer #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              en_i,
  input  logic [DATA_W-1:0] sw_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              oe_o
);
  assign rdata_o = en_i ? sw_i : '0;
  assign oe_o    = en_i;
endmodule

// File: rtl/io_out_latch.sv
module io_out_latch #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] d_i,
  output logic [DATA_W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= '0;
    else if (load_i) q_o <= d_i;
  end
endmodule

// File: rtl/iso_io_port.sv
module iso_io_port
  import iso_io_pkg::*;
#(
  parameter int unsigned ADDR_W = IO_ADDR_W,
  parameter int unsigned DATA_W = IO_DATA_W,
  parameter logic [ADDR_W-1:0] IN_ADDR  = IN_PORT_ADDR[ADDR_W-1:0],
  parameter logic [ADDR_W-1:0] OUT_ADDR = OUT_PORT_ADDR[ADDR_W-1:0]
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              io_mem_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] sw_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rd_oe_o,
  output logic [DATA_W-1:0] led_o
);
  io_sel_t sel;

  io_addr_decode #(
    .ADDR_W  (ADDR_W),
    .IN_ADDR (IN_ADDR),
    .OUT_ADDR(OUT_ADDR)
  ) u_dec (
    .addr_i  (addr_i),
    .io_mem_i(io_mem_i),
    .rd_i    (rd_i),
    .wr_i    (wr_i),
    .sel_o   (sel)
  );

  io_in_buffer #(.DATA_W(DATA_W)) u_inbuf (
    .en_i   (sel.in_rd),
    .sw_i   (sw_i),
    .rdata_o(rdata_o),
    .oe_o   (rd_oe_o)
  );

  io_out_latch #(.DATA_W(DATA_W)) u_outlat (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(sel.out_wr),
    .d_i   (wdata_i),
    .q_o   (led_o)
  );
endmodule

// File: rtl/iso_io_port_chk.sv
module iso_io_port_chk #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8,
  parameter logic [ADDR_W-1:0] IN_ADDR  = 16'h00F0,
  parameter logic [ADDR_W-1:0] OUT_ADDR = 16'h00F2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              io_mem_i,
  input logic              rd_i,
  input logic              wr_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [DATA_W-1:0] sw_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic              rd_oe_o,
  input logic [DATA_W-1:0] led_o
);
  logic out_write;
  assign out_write = wr_i && !io_mem_i && (addr_i == OUT_ADDR);

  p_reset_led_r1: assert property (@(posedge clk_i) !rst_ni |-> led_o == '0);

  p_read_data_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_oe_o |-> rdata_o == sw_i);

  p_read_hit_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !io_mem_i && addr_i == IN_ADDR) |-> rd_oe_o);

  p_load_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_write |=> led_o == $past(wdata_i));

  p_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_write |=> $stable(led_o));

  p_mem_quiet_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_mem_i |-> !rd_oe_o);

  p_no_alias_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i[ADDR_W-1:8] != '0) |-> !rd_oe_o);

  p_idle_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_oe_o |-> rdata_o == '0);

  p_both_strobes_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && wr_i && addr_i == OUT_ADDR) |-> !rd_oe_o);
endmodule

bind iso_io_port iso_io_port_chk #(
  .ADDR_W  (ADDR_W),
  .DATA_W  (DATA_W),
  .IN_ADDR (IN_ADDR),
  .OUT_ADDR(OUT_ADDR)
) u_chk (.*);

// File: tb/iso_io_port_tb_top.sv
`timescale 1ns/1ps
module iso_io_port_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        io_mem_i = 1'b0;
  logic        rd_i = 1'b0;
  logic        wr_i = 1'b0;
  logic [15:0] addr_i = '0;
  logic [7:0]  wdata_i = '0;
  logic [7:0]  sw_i = '0;
  logic [7:0]  rdata_o;
  logic        rd_oe_o;
  logic [7:0]  led_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;
  logic [7:0] exp_led = 8'h00;

  always #2.5 clk_i = ~clk_i;

  iso_io_port dut_i (.*);

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h addr=%h mem=%b rd=%b wr=%b t=%0t",
               req, act, exp, addr_i, io_mem_i, rd_i, wr_i, $time);
    end
  endtask

  // drive at negedge, sample combinational read 1 ns later
  task automatic do_read(input logic mem, input logic [15:0] a, input logic [7:0] sw,
                         input string req);
    logic hit;
    @(negedge clk_i);
    io_mem_i = mem; rd_i = 1'b1; wr_i = 1'b0; addr_i = a; sw_i = sw;
    #1;
    hit = !mem && (a == 16'h00F0);
    chk(rd_oe_o == hit, req, {15'd0, rd_oe_o}, {15'd0, hit});
    chk(rdata_o == (hit ? sw : 8'h00), req, {8'd0, rdata_o}, {8'd0, hit ? sw : 8'h00});
  endtask

  // write strobe for one cycle, led checked just after the capturing edge
  task automatic do_write(input logic mem, input logic [15:0] a, input logic [7:0] d,
                          input logic also_rd, input string req);
    @(negedge clk_i);
    io_mem_i = mem; rd_i = also_rd; wr_i = 1'b1; addr_i = a; wdata_i = d;
    if (!mem && a == 16'h00F2) exp_led = d;
    @(posedge clk_i);
    #1;
    chk(led_o == exp_led, req, {8'd0, led_o}, {8'd0, exp_led});
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : stim
    string rq;
    logic [7:0] got;
    // R1: reset state
    sw_i = 8'hA5;
    #1;
    chk(led_o == 8'h00, "R1", {8'd0, led_o}, 16'h0000);
    chk(rd_oe_o == 1'b0 && rdata_o == 8'h00, "R1", {7'd0, rd_oe_o, rdata_o}, 16'h0000);
    repeat (3) @(posedge clk_i);
    @(negedge clk_i); rst_ni = 1'b1;
    #1;
    chk(led_o == 8'h00, "R1", {8'd0, led_o}, 16'h0000);

    // R2/R3: single-bit switch patterns at the input port
    for (int k = 0; k < 8; k++) begin
      do_read(1'b0, 16'h00F0, 8'(1 << k), "R3");
      do_read(1'b0, 16'h00F0, ~8'(1 << k), "R3");
    end
    do_read(1'b0, 16'h00F0, 8'h00, "R2");
    do_read(1'b0, 16'h00F0, 8'hFF, "R2");

    // R6/R7: full I/O address sweep with reads
    for (int a = 0; a < 65536; a++) begin
      rq = (a == 16'h00F0) ? "R2" : ((a[15:8] != 0) ? "R6" : "R7");
      do_read(1'b0, 16'(a), 8'(a) ^ 8'(a >> 8) ^ 8'h5A, rq);
    end
    // R5: memory-space reads at every low address
    for (int a = 0; a < 256; a++) do_read(1'b1, 16'(a), 8'h3C ^ 8'(a), "R5");
    // R7: no strobe at the input port address
    @(negedge clk_i);
    io_mem_i = 1'b0; rd_i = 1'b0; wr_i = 1'b0; addr_i = 16'h00F0; sw_i = 8'hFF;
    #1;
    chk(rd_oe_o == 1'b0 && rdata_o == 8'h00, "R7", {7'd0, rd_oe_o, rdata_o}, 16'h0000);

    // R4/R5/R6/R7: write sweep over space select, upper byte samples, all low bytes
    for (int s = 0; s < 2; s++) begin
      for (int h = 0; h < 4; h++) begin
        for (int l = 0; l < 256; l++) begin
          logic [7:0] hb;
          hb = (h == 0) ? 8'h00 : (h == 1) ? 8'h01 : (h == 2) ? 8'h80 : 8'hFF;
          rq = (s == 1) ? "R5" : ((hb != 0) ? "R6" : ((l == 16'hF2) ? "R4" : "R7"));
          do_write(s[0], {hb, 8'(l)}, 8'(l) ^ hb ^ 8'(s * 8'h96) ^ 8'h21, 1'b0, rq);
        end
      end
    end

    // R4: hold across idle cycles
    do_write(1'b0, 16'h00F2, 8'hC3, 1'b0, "R4");
    @(negedge clk_i); wr_i = 1'b0; rd_i = 1'b0;
    repeat (5) @(posedge clk_i);
    #1;
    chk(led_o == 8'hC3, "R4", {8'd0, led_o}, 16'h00C3);

    // R8: both strobes in one cycle
    sw_i = 8'h69;
    do_write(1'b0, 16'h00F2, 8'h17, 1'b1, "R8");
    @(negedge clk_i);
    io_mem_i = 1'b0; rd_i = 1'b1; wr_i = 1'b1; addr_i = 16'h00F2; wdata_i = 8'h4E;
    #1;
    chk(rd_oe_o == 1'b0 && rdata_o == 8'h00, "R8", {7'd0, rd_oe_o, rdata_o}, 16'h0000);
    exp_led = 8'h4E;
    @(negedge clk_i);
    addr_i = 16'h00F0; wdata_i = 8'hE4;
    #1;
    chk(rd_oe_o == 1'b1 && rdata_o == 8'h69, "R8", {7'd0, rd_oe_o, rdata_o}, 16'h0169);
    @(posedge clk_i);
    #1;
    chk(led_o == 8'h4E, "R8", {8'd0, led_o}, 16'h004E);

    // R9: read switches, echo them to the LEDs
    for (int p = 0; p < 8; p++) begin
      logic [7:0] swv;
      swv = 8'(p * 37 + 11);
      @(negedge clk_i);
      io_mem_i = 1'b0; rd_i = 1'b1; wr_i = 1'b0; addr_i = 16'h00F0; sw_i = swv;
      #1;
      got = rdata_o;
      do_write(1'b0, 16'h00F2, got, 1'b0, "R9");
      chk(led_o == swv, "R9", {8'd0, led_o}, {8'd0, swv});
    end

    @(negedge clk_i);
    rd_i = 1'b0; wr_i = 1'b0;
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule